// File: doc/BRIEF.md
# Periodic Tick and Interrupt Status Unit

This block divides a reference-clock tick stream into a fixed set of periodic events: a 512 Hz base rate, eight binary sub-rates from 4 Hz to 512 Hz, a 2 Hz event and a 1 Hz event. The 1 Hz event also leaves the block as a one-cycle strobe that advances a seconds counter. The divisor comes from a two-bit select input, with one choice for each of three reference frequencies. Periodic events, an alarm-match pulse and a stopwatch-expire pulse are latched into a 16-bit status register. Software clears a status bit by writing a 1 to it.

A 16-bit enable register masks the status register. A single interrupt line is high while any enabled status bit is set. Both registers sit on a simple 16-bit register port, with a write strobe, a byte offset and a combinational read-data path. The status register is at offset 0x14 and the enable register is at offset 0x18.

Top module: `rtc_irq_tick`

## Requirements
- R1: Status bit positions are fixed. Bit 0 is the stopwatch event and bit 2 is the alarm event. Bit 4 is the 1 Hz event and bit 7 is the 2 Hz event. Bit 8+j is the sample event at 4·2^j Hz, for j = 0..7. Bits 1, 3, 5 and 6 always read 0.
- R2: The select input picks divisor DIV_A for value 0, DIV_B for value 1 and DIV_C for value 2. Value 3 uses DIV_A. Counting ref ticks from reset, the k-th base (512 Hz) event occurs on the ref tick with 1-based index ceil(k·div/512). Equivalently, ref tick n carries a base event when floor(512·n/div) increases.
- R3: Number the base events s = 1, 2, ... from reset. Sample event j fires on base event s when s is a multiple of 128/2^j. The 2 Hz event fires when s is a multiple of 256. The 1 Hz event fires when s is a multiple of 512.
- R4: sec_tick_o is high in exactly the cycle whose ref tick carries a 1 Hz event. It is combinational with ref_tick_i.
- R5: An event presented in a cycle sets its status bit at the next clock edge, whatever the enable register holds.
- R6: A write to offset 0x14 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R7: If an event and a write-1 clear of the same bit fall in the same cycle, the bit stays set.
- R8: The enable register at offset 0x18 takes all 16 write-data bits on a write and reads back unchanged.
- R9: irq_o is high exactly while the bitwise AND of status and enable is nonzero.
- R10: Reset (rst_ni low) clears status, enable and the divider phase, so irq_o is low and event counting restarts from zero.
- R11: A read of any offset other than 0x14 or 0x18 returns 0. A write to any other offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One pulse per reference-clock period |
| clk_sel_i | input | 2 | Divisor select (0: DIV_A, 1: DIV_B, 2: DIV_C, 3: DIV_A) |
| alarm_i | input | 1 | Alarm-match event pulse |
| stopwatch_i | input | 1 | Stopwatch-expire event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on reg_addr_i |
| irq_o | output | 1 | Masked interrupt request |
| sec_tick_o | output | 1 | One-second strobe for the time counter |

## Verification
Some properties are checked on every cycle. An incoming alarm, stopwatch or second event sets its status bit at the next edge. A write-1 clear removes a bit unless the same event arrives at the same time. A write of 0 keeps a set bit. The unused bit positions stay zero. The interrupt only rises when some enable bit is set, and the second strobe only appears together with a ref tick. Other behaviour only the bench's scenarios can show: the exact ref tick on which each periodic event lands for every divisor, the ratios between the taps, register readback and its masking effect on the interrupt, and the restart of the divider phase after a mid-run reset.

// File: rtl/rtc_irq_tick_pkg.sv
package rtc_irq_tick_pkg;
  localparam int DATA_W    = 16;
  localparam int BASE_LOG2 = 9;             // 512 Hz base rate
  localparam int BASE_RATE = 1 << BASE_LOG2;
  localparam int NUM_SAM   = 8;

  localparam int STAT_OFF  = 'h14;
  localparam int EN_OFF    = 'h18;

  localparam int BIT_SW    = 0;
  localparam int BIT_ALM   = 2;
  localparam int BIT_SEC   = 4;
  localparam int BIT_HALF  = 7;
  localparam int BIT_SAM0  = 8;

  localparam logic [DATA_W-1:0] USED_MASK = 16'hff95;
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_irq_tick_pkg::*;
#(
  parameter int DIV_A = 32768,
  parameter int DIV_B = 32000,
  parameter int DIV_C = 38400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_tick_i,
  input  logic [1:0]         sel_i,
  output logic [BASE_LOG2:0] tap_o   // tap_o[i]: base rate / 2^i
);
  localparam int MAX_DIV = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                           : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int ACC_W   = $clog2(MAX_DIV + BASE_RATE) + 1;

  logic [ACC_W-1:0]     acc_q, acc_sum, div_sel;
  logic [BASE_LOG2-1:0] cnt_q;
  logic                 base_hit;

  always_comb begin
    unique case (sel_i)
      2'd1:    div_sel = ACC_W'(DIV_B);
      2'd2:    div_sel = ACC_W'(DIV_C);
      default: div_sel = ACC_W'(DIV_A);
    endcase
  end

  // phase accumulator: exactly BASE_RATE hits per div ref ticks
  assign acc_sum  = acc_q + ACC_W'(BASE_RATE);
  assign base_hit = ref_tick_i && (acc_sum >= div_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (ref_tick_i) begin
      acc_q <= base_hit ? (acc_sum - div_sel) : acc_sum;
      if (base_hit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tap_o[0] = base_hit;
  for (genvar i = 1; i <= BASE_LOG2; i++) begin : g_tap
    assign tap_o[i] = base_hit && (&cnt_q[i-1:0]);
  end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] event_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              en_we_i,
  input  logic [DATA_W-1:0] en_wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | event_i;  // new event beats clear
      if (en_we_i) enable_q <= en_wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);
endmodule

// File: rtl/rtc_irq_tick.sv
module rtc_irq_tick
  import rtc_irq_tick_pkg::*;
#(
  parameter int DIV_A  = 32768,
  parameter int DIV_B  = 32000,
  parameter int DIV_C  = 38400,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              alarm_i,
  input  logic              stopwatch_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              sec_tick_o
);
  logic [BASE_LOG2:0] tap;
  logic [DATA_W-1:0]  events, clr, status_q, enable_q;
  logic               hit_stat, hit_en;

  rtc_tick_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .sel_i      (clk_sel_i),
    .tap_o      (tap)
  );

  always_comb begin
    events           = '0;
    events[BIT_SW]   = stopwatch_i;
    events[BIT_ALM]  = alarm_i;
    events[BIT_SEC]  = tap[BASE_LOG2];
    events[BIT_HALF] = tap[BASE_LOG2-1];
    for (int j = 0; j < NUM_SAM; j++)
      events[BIT_SAM0+j] = tap[NUM_SAM-1-j];  // sample j: 4*2^j Hz
  end

  assign hit_stat = (reg_addr_i == ADDR_W'(STAT_OFF));
  assign hit_en   = (reg_addr_i == ADDR_W'(EN_OFF));
  assign clr      = (reg_we_i && hit_stat) ? reg_wdata_i : '0;

  rtc_irq_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (events),
    .clr_i      (clr),
    .en_we_i    (reg_we_i && hit_en),
    .en_wdata_i (reg_wdata_i),
    .status_o   (status_q),
    .enable_o   (enable_q),
    .irq_o      (irq_o)
  );

  assign reg_rdata_o = hit_stat ? status_q : (hit_en ? enable_q : '0);
  assign sec_tick_o  = tap[BASE_LOG2];
endmodule

// File: rtl/rtc_irq_tick_chk.sv
module rtc_irq_tick_chk
  import rtc_irq_tick_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_tick_i,
  input logic              alarm_i,
  input logic              stopwatch_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [15:0]       reg_wdata_i,
  input logic              irq_o,
  input logic              sec_tick_o,
  input logic [15:0]       status_q,
  input logic [15:0]       enable_q
);
  logic stat_wr;
  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_W'(STAT_OFF));

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~USED_MASK) == '0);                                    // R1
  AST_SEC_WITH_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> ref_tick_i);                                        // R4
  AST_ALARM_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> status_q[BIT_ALM]);                                    // R5
  AST_SEC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> status_q[BIT_SEC]);                                 // R5
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && reg_wdata_i[BIT_ALM] && !alarm_i) |=> !status_q[BIT_ALM]); // R6
  AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !reg_wdata_i[BIT_SW] && status_q[BIT_SW]) |=> status_q[BIT_SW]); // R6
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && reg_wdata_i[BIT_SW] && stopwatch_i) |=> status_q[BIT_SW]); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (enable_q != '0));                                       // R9
endmodule

bind rtc_irq_tick rtc_irq_tick_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_tick_i  (ref_tick_i),
  .alarm_i     (alarm_i),
  .stopwatch_i (stopwatch_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .sec_tick_o  (sec_tick_o),
  .status_q    (status_q),
  .enable_q    (enable_q)
);

// File: tb/rtc_irq_tick_tb.sv
module rtc_irq_tick_tb_top;
  localparam int DA = 1024, DB = 1000, DC = 1200;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0, alarm_i = 1'b0, stopwatch_i = 1'b0, reg_we_i = 1'b0;
  logic [1:0]  clk_sel_i = 2'd0;
  logic [5:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o, sec_tick_o;

  always #4 clk_i = ~clk_i;

  rtc_irq_tick #(.DIV_A(DA), .DIV_B(DB), .DIV_C(DC), .ADDR_W(6)) dut_i (.*);

  int unsigned vec_cnt = 0, err_cnt = 0;
  logic [15:0] m_stat, m_en;
  longint      m_n, m_s, m_div;
  bit          done = 0;

  function automatic longint div_of(input logic [1:0] s);
    case (s)
      2'd1: return DB;
      2'd2: return DC;
      default: return DA;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  endtask

  // drive one cycle at negedge, check outputs, advance model
  task automatic step(input logic tick, input logic al, input logic sw,
                      input logic we, input logic [5:0] addr, input logic [15:0] wd);
    logic [15:0] ev, clr;
    logic        hit;
    longint      s_new;
    ref_tick_i = tick; alarm_i = al; stopwatch_i = sw;
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd;
    #1;
    s_new = m_s;
    hit   = 1'b0;
    if (tick) begin
      s_new = (512 * (m_n + 1)) / m_div;
      hit   = (s_new != m_s);
    end
    chk("R2 R4", "sec_tick", {15'b0, sec_tick_o}, {15'b0, hit && (s_new % 512 == 0)});
    if (addr == 6'h14)      chk("R1 R3 R5 R6 R7", "status", reg_rdata_o, m_stat);
    else if (addr == 6'h18) chk("R8", "enable", reg_rdata_o, m_en);
    else                    chk("R11", "other", reg_rdata_o, 16'h0);
    chk("R9", "irq", {15'b0, irq_o}, {15'b0, |(m_stat & m_en)});
    ev = '0;
    ev[0] = sw;
    ev[2] = al;
    if (hit) begin
      ev[4] = (s_new % 512 == 0);
      ev[7] = (s_new % 256 == 0);
      for (int j = 0; j < 8; j++) ev[8+j] = (s_new % (128 >> j) == 0);
    end
    if (tick) begin m_n++; m_s = s_new; end
    clr = (we && addr == 6'h14) ? wd : 16'h0;
    m_stat = (m_stat & ~clr) | ev;
    if (we && addr == 6'h18) m_en = wd;
    @(negedge clk_i);
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk_i);
    rst_ni = 1'b0; ref_tick_i = 0; alarm_i = 0; stopwatch_i = 0; reg_we_i = 0;
    clk_sel_i = sel;
    reg_addr_i = 6'h14; #1;
    chk("R10", "reset status", reg_rdata_o, 16'h0);
    reg_addr_i = 6'h18; #1;
    chk("R10", "reset enable", reg_rdata_o, 16'h0);
    chk("R10", "reset irq", {15'b0, irq_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_stat = '0; m_en = '0; m_n = 0; m_s = 0; m_div = div_of(sel);
  endtask

  task automatic directed();
    step(0, 0, 0, 1, 6'h18, 16'hffff);   // R8
    step(0, 1, 0, 0, 6'h18, 16'h0);      // alarm R5
    step(0, 0, 0, 1, 6'h14, 16'h0000);   // write 0 keeps R6
    step(0, 0, 1, 0, 6'h14, 16'h0);
    step(0, 0, 1, 1, 6'h14, 16'h0005);   // clear with event R7
    step(0, 0, 0, 0, 6'h14, 16'h0);
    step(0, 0, 0, 1, 6'h18, 16'h0004);   // mask stopwatch R9
    step(0, 0, 0, 0, 6'h14, 16'h0);
    step(0, 0, 0, 1, 6'h20, 16'hffff);   // other offset R11
    step(0, 0, 0, 0, 6'h20, 16'h0);
    step(0, 0, 0, 0, 6'h18, 16'h0);
    step(0, 0, 0, 1, 6'h14, 16'hffff);
    step(0, 0, 0, 0, 6'h14, 16'h0);
  endtask

  task automatic random_run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic [5:0] a;
      case ($urandom % 4)
        0, 1: a = 6'h14;
        2:    a = 6'h18;
        default: a = 6'($urandom);
      endcase
      step(($urandom % 8) != 0, ($urandom % 64) == 0, ($urandom % 64) == 0,
           ($urandom % 8) == 0, a, 16'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < 3; s++) begin
      do_reset(2'(s));
      directed();
      random_run(5000);
    end
    do_reset(2'd3);
    random_run(1500);
    random_run(300);
    do_reset(2'd1);                      // mid-run reset restarts phase R10
    random_run(1500);
    done = 1;
    summary();
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule